// File: doc/BRIEF.md
# Error and Warning Summary Unit

This unit gathers single-cycle error and warning events from an encoder front end into a sticky status register. From those latched events it builds two low-active summary bits, one for errors and one for warnings, which a serial readout path samples. It also drives the enable of a pull-down on a shared, wired-OR fault pin. Other devices on the same line can pull that pin low; the unit samples the line back as an external error that is never latched.

Some messages always reach the error bit. Others reach it only in certain operating modes. A third group is routed through an 8-bit configuration mask, in which a 0 enables a message and a 1 suppresses it. When the temperature error is routed to the error bit and is latched, three degrade flags are raised for the analog side.

The status register is read through a plain output and cleared by a read strobe. The ROM-invalid bit survives that strobe and is removed only by the soft-reset command. The summary bits, the pull-down enable and the degrade flags are all registered.

Top module: `err_warn_agg`

## Requirements
- R1: After reset, `status_o` is 0, `err_n_o` and `warn_n_o` are 1, and `fault_pd_o` and all three degrade flags are 0.
- R2: A 1 on `evt_i[k]` sets `status_o[k]` at the next clock edge, and the bit stays set with no further event. Bit positions: 0 ROM invalid, 1 command failure, 2 configuration CRC, 3 link error, 4 turn error, 5 turn count, 6 sync startup, 7 sync count, 8 amplitude high, 9 amplitude low, 10 temperature error, 11 frequency warning, 12 gain-control high, 13 gain-control low, 14 temperature warning, 15 turn warning.
- R3: A `rd_clr_i` pulse clears every status bit except bit 0. A bit whose event is high in the same cycle stays set.
- R4: `soft_res_i` clears status bit 0 and leaves every other bit unchanged.
- R5: Status bits 0, 1 and 2 always drive `err_n_o` low. Bit 1 also drives `warn_n_o` low.
- R6: Bit 3 reaches the error bit only while `nbiss_i` = 1. Bits 4 and 5 reach it only while `turn_mode_i` is 2'b01 or 2'b10. Bit 6 reaches it only while `sync_start_i` = 1.
- R7: Error mask fields in `cfg_i` (0 enables): bit 7 for status bits 8/9, bit 6 for the external error, bit 5 for status bit 10.
- R8: Warning mask fields in `cfg_i` (0 enables): bit 4 for status bit 11, bit 3 for bits 8/9, bit 2 for bits 12/13, bit 1 for bit 14, bit 0 for bit 15.
- R9: A low level on `fault_pin_i` that this unit did not cause is an external error. It drives `err_n_o` low on the third clock edge after the pin falls, while `cfg_i[6]` = 0. It returns high by the same timing when the pin is released, and it sets no status bit.
- R10: `fault_pd_o` is 1 whenever an internal message drives the error bit. Status bit 7 sets `fault_pd_o` whatever the mask and mode inputs are, without affecting `err_n_o`.
- R11: While status bit 10 is set and `cfg_i[5]` = 0, `setpt_min_o`, `ana_mid_o` and `drv_lim_o` are 1; otherwise they are 0.
- R12: The summary outputs change on the clock edge after a change in status, configuration or mode, not within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 16 | Event pulses, one per status bit |
| cfg_i | input | 8 | Error/warning mask, 0 enables |
| nbiss_i | input | 1 | Mode enabling the link error |
| turn_mode_i | input | 2 | Multiturn mode field |
| sync_start_i | input | 1 | Startup mode selects nonius synchronization |
| rd_clr_i | input | 1 | Status read strobe, clears bits 15..1 |
| soft_res_i | input | 1 | Soft-reset command, clears bit 0 |
| fault_pin_i | input | 1 | Sampled level of the wired-OR fault line, low = fault |
| status_o | output | 16 | Sticky status register |
| err_n_o | output | 1 | Error summary, active low |
| warn_n_o | output | 1 | Warning summary, active low |
| fault_pd_o | output | 1 | Pull-down enable for the fault line |
| setpt_min_o | output | 1 | Degrade flag: controller setpoint to minimum |
| ana_mid_o | output | 1 | Degrade flag: analog outputs to mid-supply |
| drv_lim_o | output | 1 | Degrade flag: line-driver current limited |

## Verification
A stuck or wrongly cleared status bit shows on `status_o` one cycle after the event or strobe. It reaches `err_n_o` or `warn_n_o` one cycle after that. A wrong routing term shows only when its mode or mask bit is toggled. For that reason each gate is tested in both states while the latched event stays present, and the summary is expected to follow one edge later. Faults on the external path show as a wrong delay, or as a status bit set where none should be. A pull-down that feeds back into the unit would show as an error bit that stays low after the internal cause is cleared.

// File: rtl/ewa_pkg.sv
package ewa_pkg;
  localparam int NUM_EVT = 16;
  localparam int CFG_W   = 8;
  localparam int TM_W    = 2;

  localparam int S_ROM_BAD    = 0;
  localparam int S_CMD_FAIL   = 1;
  localparam int S_CFG_CRC    = 2;
  localparam int S_LINK       = 3;
  localparam int S_TURN_ERR   = 4;
  localparam int S_TURN_CNT   = 5;
  localparam int S_SYNC_START = 6;
  localparam int S_SYNC_CNT   = 7;
  localparam int S_AMP_HI     = 8;
  localparam int S_AMP_LO     = 9;
  localparam int S_TEMP_ERR   = 10;
  localparam int S_FREQ_WARN  = 11;
  localparam int S_AGC_HI     = 12;
  localparam int S_AGC_LO     = 13;
  localparam int S_TEMP_WARN  = 14;
  localparam int S_TURN_WARN  = 15;

  // mask bit positions, 0 = enabled
  localparam int M_ERR_AMP   = 7;
  localparam int M_ERR_EXT   = 6;
  localparam int M_ERR_TEMP  = 5;
  localparam int M_WRN_FREQ  = 4;
  localparam int M_WRN_AMP   = 3;
  localparam int M_WRN_AGC   = 2;
  localparam int M_WRN_TEMP  = 1;
  localparam int M_WRN_TURN  = 0;

  // bits only removed by the soft-reset command
  localparam logic [NUM_EVT-1:0] KEEP_MASK = NUM_EVT'(1) << S_ROM_BAD;

  typedef struct packed {
    logic err_n;
    logic warn_n;
    logic pd;
    logic degrade;
  } summary_t;
endpackage

// File: rtl/ewa_sync.sv
module ewa_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= {STAGES{RST_VAL}};
    else       sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ewa_status.sv
module ewa_status #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     KEEP = '0
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] evt_i,
  input  logic         rd_clr_i,
  input  logic         soft_res_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (rd_clr_i)   clr_vec = clr_vec | ~KEEP;
    if (soft_res_i) clr_vec = clr_vec | KEEP;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= '0;
    else       st_q <= (st_q & ~clr_vec) | evt_i;
  end

  assign st_o = st_q;

  // R2
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|evt_i) |=> ((st_q & $past(evt_i)) == $past(evt_i)));

  // R3
  read_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_clr_i |=> ((st_q & ~$past(evt_i) & ~KEEP) == '0));

  // R4
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    soft_res_i |=> ((st_q & ~$past(evt_i) & KEEP) == '0));
endmodule

// File: rtl/ewa_route.sv
module ewa_route
  import ewa_pkg::*;
#(
  parameter int W = NUM_EVT
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [W-1:0]     st_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             nbiss_i,
  input  logic [TM_W-1:0]  turn_mode_i,
  input  logic             sync_start_i,
  input  logic             ext_err_i,
  output summary_t         sum_o
);
  logic turn_on;
  logic err_int, err_any, warn_any, deg_d;
  summary_t sum_q;

  always_comb begin
    turn_on = (turn_mode_i == 2'b01) || (turn_mode_i == 2'b10);

    err_int = st_i[S_ROM_BAD] | st_i[S_CMD_FAIL] | st_i[S_CFG_CRC]
            | (st_i[S_LINK] & nbiss_i)
            | ((st_i[S_TURN_ERR] | st_i[S_TURN_CNT]) & turn_on)
            | (st_i[S_SYNC_START] & sync_start_i)
            | ((st_i[S_AMP_HI] | st_i[S_AMP_LO]) & ~cfg_i[M_ERR_AMP])
            | (st_i[S_TEMP_ERR] & ~cfg_i[M_ERR_TEMP]);

    err_any = err_int | (ext_err_i & ~cfg_i[M_ERR_EXT]);

    warn_any = st_i[S_CMD_FAIL]
             | (st_i[S_FREQ_WARN] & ~cfg_i[M_WRN_FREQ])
             | ((st_i[S_AMP_HI] | st_i[S_AMP_LO]) & ~cfg_i[M_WRN_AMP])
             | ((st_i[S_AGC_HI] | st_i[S_AGC_LO]) & ~cfg_i[M_WRN_AGC])
             | (st_i[S_TEMP_WARN] & ~cfg_i[M_WRN_TEMP])
             | (st_i[S_TURN_WARN] & ~cfg_i[M_WRN_TURN]);

    deg_d = st_i[S_TEMP_ERR] & ~cfg_i[M_ERR_TEMP];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sum_q <= '{err_n: 1'b1, warn_n: 1'b1, pd: 1'b0, degrade: 1'b0};
    end else begin
      sum_q.err_n   <= ~err_any;
      sum_q.warn_n  <= ~warn_any;
      // external line level is excluded so the pull-down never feeds itself
      sum_q.pd      <= err_int | st_i[S_SYNC_CNT];
      sum_q.degrade <= deg_d;
    end
  end

  assign sum_o = sum_q;

  // R5
  fixed_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    st_i[S_CFG_CRC] |=> !sum_q.err_n);

  // R10
  sync_bypass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    st_i[S_SYNC_CNT] |=> sum_q.pd);

  // R11
  degrade_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i[S_TEMP_ERR] && !cfg_i[M_ERR_TEMP]) |=> sum_q.degrade);

  // R10
  pd_follows_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (st_i[S_ROM_BAD] || st_i[S_CMD_FAIL]) |=> (sum_q.pd && !sum_q.err_n));
endmodule

// File: rtl/err_warn_agg.sv
module err_warn_agg
  import ewa_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic                nbiss_i,
  input  logic [TM_W-1:0]     turn_mode_i,
  input  logic                sync_start_i,
  input  logic                rd_clr_i,
  input  logic                soft_res_i,
  input  logic                fault_pin_i,
  output logic [NUM_EVT-1:0]  status_o,
  output logic                err_n_o,
  output logic                warn_n_o,
  output logic                fault_pd_o,
  output logic                setpt_min_o,
  output logic                ana_mid_o,
  output logic                drv_lim_o
);
  localparam int SYNC_STAGES = 2;

  logic [NUM_EVT-1:0] st;
  logic               pin_q, pd_q, ext_err;
  summary_t           sum;

  ewa_status #(.W(NUM_EVT), .KEEP(KEEP_MASK)) u_status (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(evt_i),
    .rd_clr_i(rd_clr_i), .soft_res_i(soft_res_i), .st_o(st)
  );

  ewa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(fault_pin_i), .q_o(pin_q)
  );

  // own pull-down delayed to line up with the synchronized pin level
  ewa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_align (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(sum.pd), .q_o(pd_q)
  );

  assign ext_err = ~pin_q & ~pd_q;

  ewa_route #(.W(NUM_EVT)) u_route (
    .clk_i(clk_i), .rst_i(rst_i), .st_i(st), .cfg_i(cfg_i),
    .nbiss_i(nbiss_i), .turn_mode_i(turn_mode_i),
    .sync_start_i(sync_start_i), .ext_err_i(ext_err), .sum_o(sum)
  );

  assign status_o    = st;
  assign err_n_o     = sum.err_n;
  assign warn_n_o    = sum.warn_n;
  assign fault_pd_o  = sum.pd;
  assign setpt_min_o = sum.degrade;
  assign ana_mid_o   = sum.degrade;
  assign drv_lim_o   = sum.degrade;

  // R9
  ext_unlatched_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_i == '0 && !rd_clr_i && !soft_res_i) |=> (st == $past(st)));
endmodule

// File: tb/err_warn_agg_test.sv
module err_warn_agg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] evt = '0;
  logic [7:0]  cfg = 8'hFF;
  logic        nbiss = 1'b0;
  logic [1:0]  tmode = 2'b00;
  logic        sstart = 1'b0;
  logic        rdclr = 1'b0;
  logic        sres = 1'b0;
  logic        ext_pull = 1'b0;
  logic        pin;
  logic [15:0] status;
  logic        err_n, warn_n, pd, setpt, amid, dlim;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign pin = ~(pd | ext_pull);

  err_warn_agg uut (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .cfg_i(cfg), .nbiss_i(nbiss),
    .turn_mode_i(tmode), .sync_start_i(sstart), .rd_clr_i(rdclr),
    .soft_res_i(sres), .fault_pin_i(pin), .status_o(status),
    .err_n_o(err_n), .warn_n_o(warn_n), .fault_pd_o(pd),
    .setpt_min_o(setpt), .ana_mid_o(amid), .drv_lim_o(dlim)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(logic [15:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    rdclr = 1'b1; sres = 1'b1;
    @(negedge clk);
    rdclr = 1'b0; sres = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    // R1
    chk("R1 status", status, 0);
    chk("R1 err_n", err_n, 1);
    chk("R1 warn_n", warn_n, 1);
    chk("R1 pd", pd, 0);
    chk("R1 degrade", {setpt, amid, dlim}, 0);
  endtask

  task automatic t_latch();
    // R2
    evt = 16'h0100;
    @(negedge clk);
    evt = '0;
    chk("R2 set", status, 16'h0100);
    repeat (3) @(negedge clk);
    chk("R2 held", status, 16'h0100);
    chk("R7 amp masked", err_n, 1);
    clear_all();
  endtask

  task automatic t_clear();
    pulse(16'h8001);
    // R3: strobe with a coincident frequency warning event
    rdclr = 1'b1; evt = 16'h0800;
    @(negedge clk);
    rdclr = 1'b0; evt = '0;
    chk("R3 keep bit0 and new event", status, 16'h0801);
    // R4
    sres = 1'b1;
    @(negedge clk);
    sres = 1'b0;
    chk("R4 soft reset", status, 16'h0800);
    clear_all();
  endtask

  task automatic t_fixed();
    // R5
    pulse(16'h0004);
    chk("R5 crc err", err_n, 0);
    chk("R5 crc no warn", warn_n, 1);
    chk("R10 pd with err", pd, 1);
    clear_all();
    chk("R10 released", {err_n, pd}, 2'b10);
    pulse(16'h0002);
    chk("R5 cmd err+warn", {err_n, warn_n}, 2'b00);
    clear_all();
    pulse(16'h0001);
    chk("R5 rom err", err_n, 0);
    clear_all();
  endtask

  task automatic t_modes();
    // R6
    pulse(16'h0008);
    chk("R6 link gated", err_n, 1);
    nbiss = 1'b1; @(negedge clk);
    chk("R6 link on", err_n, 0);
    nbiss = 1'b0;
    clear_all();
    pulse(16'h0020);
    chk("R6 turn 00", err_n, 1);
    tmode = 2'b01; @(negedge clk);
    chk("R6 turn 01", err_n, 0);
    tmode = 2'b11; @(negedge clk);
    chk("R6 turn 11", err_n, 1);
    tmode = 2'b10; @(negedge clk);
    chk("R6 turn 10", err_n, 0);
    tmode = 2'b00;
    clear_all();
    pulse(16'h0040);
    chk("R6 sync start gated", err_n, 1);
    sstart = 1'b1; @(negedge clk);
    chk("R6 sync start on", err_n, 0);
    sstart = 1'b0;
    clear_all();
  endtask

  task automatic t_mask_err();
    // R7 / R11
    pulse(16'h0600);
    chk("R7 all masked", {err_n, setpt}, 2'b10);
    cfg = 8'h7F; @(negedge clk);
    chk("R7 amp enabled", err_n, 0);
    cfg = 8'hDF; @(negedge clk);
    chk("R7 temp enabled", err_n, 0);
    chk("R11 degrade on", {setpt, amid, dlim}, 3'b111);
    cfg = 8'hFF; @(negedge clk);
    chk("R11 degrade off", {err_n, setpt, amid, dlim}, 4'b1000);
    clear_all();
  endtask

  task automatic t_mask_warn();
    // R8
    pulse(16'h0800);
    chk("R8 freq masked", warn_n, 1);
    cfg = 8'hEF; @(negedge clk);
    chk("R8 freq on", warn_n, 0);
    cfg = 8'hFF; clear_all();
    pulse(16'h2000);
    cfg = 8'hFB; @(negedge clk);
    chk("R8 agc on", warn_n, 0);
    cfg = 8'hFF; clear_all();
    pulse(16'h4000);
    cfg = 8'hFD; @(negedge clk);
    chk("R8 temp warn on", warn_n, 0);
    cfg = 8'hFF; clear_all();
    pulse(16'h8000);
    cfg = 8'hFE; @(negedge clk);
    chk("R8 turn warn on", warn_n, 0);
    cfg = 8'hFF; clear_all();
    pulse(16'h0100);
    cfg = 8'hF7; @(negedge clk);
    chk("R8 amp warn only", {err_n, warn_n}, 2'b10);
    cfg = 8'hFF; clear_all();
  endtask

  task automatic t_ext();
    // R9
    cfg = 8'hBF;
    @(negedge clk);
    ext_pull = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 not yet", err_n, 1);
    @(negedge clk);
    chk("R9 ext err", err_n, 0);
    chk("R9 no status", status, 0);
    chk("R9 no pd", pd, 0);
    ext_pull = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 still low", err_n, 0);
    @(negedge clk);
    chk("R9 released", err_n, 1);
    chk("R9 not latched", status, 0);
    cfg = 8'hFF;
    @(negedge clk);
  endtask

  task automatic t_sync();
    // R10
    pulse(16'h0080);
    chk("R10 sync bypass pd", pd, 1);
    chk("R10 sync no err", err_n, 1);
    clear_all();
  endtask

  task automatic t_reg();
    // R12
    pulse(16'h4000);
    cfg = 8'hFD;
    #1;
    chk("R12 same cycle", warn_n, 1);
    @(negedge clk);
    chk("R12 next edge", warn_n, 0);
    cfg = 8'hFF; clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latch();
    t_clear();
    t_fixed();
    t_modes();
    t_mask_err();
    t_mask_warn();
    t_ext();
    t_sync();
    t_reg();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule